// File: doc/BRIEF.md
# Serial Word Receiver with Write-Strobe Regeneration

This block sits at the display end of a serial link. A framed serial bit stream arrives together with its forwarded bit clock. The block detects each frame and rebuilds the 20-bit word it carries. It presents the word on a parallel bus and then produces an active-low write strobe of fixed width for a display controller. The word is already stable on the bus before the strobe falls, so the controller can latch it on either strobe edge.

Each frame is one start bit at 1 on a line that idles low, then twenty data bits with the least significant bit first, then one stop bit at 0. A frame whose stop bit reads 1 is thrown away and sets a sticky framing-error flag. Two active-low mode inputs set the outputs:

- Reset clears the bus and holds the strobe high.
- Standby freezes the bus and holds the strobe high.
- Either mode abandons a frame that is partly received.

An edge-rate select input has no logical effect. It is registered and returned as a status bit.

Top module: `wstrb_deser_rx`

## Requirements
- R1: While `rst_n` is sampled low, the next cycle shows `word_out` = 0, `wclk_n` = 1 and `frame_err` = 0, and any partly received frame is discarded.
- R2: While `rst_n` = 1 and `stby_n` = 0, `wclk_n` stays 1 and `word_out` keeps the value it had before standby, whatever arrives on `sdata`.
- R3: In operating mode, the receiver finds a start bit of 1 on a line idling at 0. It then takes 20 data bits, bit 0 first, and accepts the word if the following stop bit is 0. The accepted word appears on `word_out` and is followed by exactly one strobe pulse.
- R4: `word_out` changes no later than the clock edge one cycle before `wclk_n` falls, and it is stable at the fall.
- R5: Each `wclk_n` low pulse lasts exactly `LOW_CYC` clock cycles (default 14).
- R6: A frame whose stop bit is 1 produces no strobe and leaves `word_out` unchanged. It sets `frame_err`, which stays 1 until reset, including through later good frames.
- R7: A word that completes while a strobe is in progress is kept. It is presented only after `wclk_n` has been high for at least one cycle, and words come out in arrival order.
- R8: Entering standby abandons a partly received frame. After return to operating mode, the receiver hunts for a new start bit, and the abandoned frame produces no strobe.
- R9: `edge_sel_q` follows `edge_sel` one cycle later (0 under reset), and `edge_sel` has no effect on `word_out` or `wclk_n`.
- R10: Frames sent back to back, with a start bit directly after the previous stop bit (22 cycles per frame), are all received.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Forwarded serial bit clock |
| rst_n | input | 1 | Synchronous active-low reset mode |
| stby_n | input | 1 | Synchronous active-low standby mode |
| sdata | input | 1 | Serial data, sampled on the rising edge |
| edge_sel | input | 1 | Output edge-rate select, status only |
| word_out | output | 20 | Rebuilt parallel word |
| wclk_n | output | 1 | Regenerated active-low write strobe |
| edge_sel_q | output | 1 | Registered edge-rate select |
| frame_err | output | 1 | Sticky framing-error flag |

## Verification
The bench drives frames with the stop bit sent as 0 or as 1.

- **Word packing:** an all-ones word and single-bit words at both ends catch a reversed bit order or an off-by-one shift. Such a design would present a shifted or mirrored word.
- **Strobe overlap:** the bench is built with a strobe longer than one frame and sends frames back to back. A design without a holding slot would lose the second word or fire overlapping strobes. A design with a wrong low-time count gives pulses of the wrong width.
- **Partial frames:** reset and standby are entered in the middle of a frame. A receiver that kept its bit count would later emit a corrupted word.
- **Framing errors:** a bad stop bit must leave the bus untouched and the flag set through later good frames.

// File: rtl/wsd_pkg.sv
// Package: shared state encodings for the serial word receiver.
// Assumes: nothing beyond the importing modules' own parameters.
package wsd_pkg;

    // Frame receiver states.
    typedef enum logic [1:0] {
        RX_HUNT = 2'd0,
        RX_DATA = 2'd1,
        RX_STOP = 2'd2
    } rx_state_t;

    // Write-strobe generator states.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_LOW   = 2'd2,
        ST_REC   = 2'd3
    } st_state_t;

endpackage

// File: rtl/wsd_deframer.sv
// Module: wsd_deframer
// Finds a start bit of 1 on the idle-low line and shifts in WORD_W bits,
// least significant first. It then checks the stop bit: a 0 emits the word
// with a one-cycle valid pulse, a 1 sets a sticky error flag instead.
// Assumes: run low (standby) abandons any frame in progress; rst_n is
// synchronous and active low.
module wsd_deframer
    import wsd_pkg::*;
#(
    parameter int WORD_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              sdata,
    output logic [WORD_W-1:0] word_o,
    output logic              valid_o,
    output logic              ferr_o
);

    localparam int CNT_W = $clog2(WORD_W + 1);

    rx_state_t          state;
    logic [CNT_W-1:0]   bit_cnt;
    logic [WORD_W-1:0]  shreg;

    // Frame state machine, shift register and word/error outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= RX_HUNT;
            bit_cnt <= '0;
            shreg   <= '0;
            word_o  <= '0;
            valid_o <= 1'b0;
            ferr_o  <= 1'b0;
        end else if (!run) begin
            state   <= RX_HUNT;
            bit_cnt <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            case (state)
                RX_HUNT: begin
                    if (sdata) begin
                        state   <= RX_DATA;
                        bit_cnt <= '0;
                    end
                end
                RX_DATA: begin
                    shreg <= {sdata, shreg[WORD_W-1:1]};
                    if (bit_cnt == CNT_W'(WORD_W - 1)) begin
                        state <= RX_STOP;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                RX_STOP: begin
                    state <= RX_HUNT;
                    if (!sdata) begin
                        word_o  <= shreg;
                        valid_o <= 1'b1;
                    end else begin
                        ferr_o <= 1'b1;
                    end
                end
                default: state <= RX_HUNT;
            endcase
        end
    end

    AST_FERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ferr_o |=> ferr_o); // R6

    AST_STBY_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (state == RX_HUNT && !valid_o)); // R8

endmodule

// File: rtl/wsd_strobe.sv
// Module: wsd_strobe
// Loads each received word into the output register, waits one cycle with
// the strobe high, then drives the strobe low for LOW_CYC cycles and high
// for one recovery cycle. A word arriving while busy waits in a one-entry
// holding slot.
// Assumes: words arrive no faster than one per frame time, so a single
// holding slot is enough.
module wsd_strobe
    import wsd_pkg::*;
#(
    parameter int WORD_W  = 20,
    parameter int LOW_CYC = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [WORD_W-1:0] word_i,
    input  logic              valid_i,
    output logic [WORD_W-1:0] data_o,
    output logic              wclk_n_o
);

    localparam int LCNT_W = $clog2(LOW_CYC + 1);

    st_state_t          state;
    logic [LCNT_W-1:0]  low_cnt;
    logic [WORD_W-1:0]  pend_word;
    logic               pend_vld;
    logic               take_new;

    // A new word goes straight to the output only when idle with nothing held.
    assign take_new = (state == ST_IDLE) && !pend_vld;

    // Strobe sequencing, output register and holding slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            low_cnt   <= '0;
            data_o    <= '0;
            pend_word <= '0;
            pend_vld  <= 1'b0;
        end else if (!run) begin
            state    <= ST_IDLE;
            low_cnt  <= '0;
            pend_vld <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (pend_vld) begin
                        data_o   <= pend_word;
                        pend_vld <= 1'b0;
                        state    <= ST_SETUP;
                    end else if (valid_i) begin
                        data_o <= word_i;
                        state  <= ST_SETUP;
                    end
                end
                ST_SETUP: begin
                    state   <= ST_LOW;
                    low_cnt <= '0;
                end
                ST_LOW: begin
                    if (low_cnt == LCNT_W'(LOW_CYC - 1)) begin
                        state <= ST_REC;
                    end else begin
                        low_cnt <= low_cnt + 1'b1;
                    end
                end
                ST_REC:  state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
            if (valid_i && !take_new) begin
                pend_word <= word_i;
                pend_vld  <= 1'b1;
            end
        end
    end

    // The strobe is low only in the low phase.
    assign wclk_n_o = (state != ST_LOW);

    AST_RESET_OUT: assert property (@(posedge clk)
        !rst_n |=> (data_o == '0 && wclk_n_o)); // R1

    AST_STBY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (wclk_n_o && $stable(data_o))); // R2

    AST_SETUP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wclk_n_o) |-> $stable(data_o)); // R4

    AST_HIGH_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wclk_n_o) |=> wclk_n_o); // R7

endmodule

// File: rtl/wstrb_deser_rx.sv
// Module: wstrb_deser_rx (top)
// Serial word receiver: deframer feeding the write-strobe generator, plus a
// registered edge-rate status bit.
// Assumes: clk is the forwarded serial clock; both mode inputs are already
// synchronous to it.
module wstrb_deser_rx #(
    parameter int WORD_W  = 20,
    parameter int LOW_CYC = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stby_n,
    input  logic              sdata,
    input  logic              edge_sel,
    output logic [WORD_W-1:0] word_out,
    output logic              wclk_n,
    output logic              edge_sel_q,
    output logic              frame_err
);

    logic [WORD_W-1:0] rx_word;
    logic              rx_valid;

    wsd_deframer #(.WORD_W(WORD_W)) u_deframer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (stby_n),
        .sdata   (sdata),
        .word_o  (rx_word),
        .valid_o (rx_valid),
        .ferr_o  (frame_err)
    );

    wsd_strobe #(.WORD_W(WORD_W), .LOW_CYC(LOW_CYC)) u_strobe (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (stby_n),
        .word_i   (rx_word),
        .valid_i  (rx_valid),
        .data_o   (word_out),
        .wclk_n_o (wclk_n)
    );

    // Edge-rate select: status only, no logical effect.
    always_ff @(posedge clk) begin
        if (!rst_n) edge_sel_q <= 1'b0;
        else        edge_sel_q <= edge_sel;
    end

    AST_EDGE_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (edge_sel_q == $past(edge_sel))); // R9

endmodule

// File: tb/wstrb_deser_rx_tb_top.sv
// Scoreboard bench: the frame driver pushes expected words into a queue and
// the strobe monitor pops and compares them at each strobe fall.
module wstrb_deser_rx_tb_top;

    localparam int W    = 20;
    localparam int LOWC = 24;   // longer than one frame, so words can overlap a pulse

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         stby_n = 1'b1;
    logic         sdata = 1'b0;
    logic         edge_sel = 1'b0;
    logic [W-1:0] word_out;
    logic         wclk_n;
    logic         edge_sel_q;
    logic         frame_err;

    int total = 0;
    int bad   = 0;
    logic [W-1:0] exp_q[$];

    always #10 clk = ~clk;

    wstrb_deser_rx #(.WORD_W(W), .LOW_CYC(LOWC)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .stby_n     (stby_n),
        .sdata      (sdata),
        .edge_sel   (edge_sel),
        .word_out   (word_out),
        .wclk_n     (wclk_n),
        .edge_sel_q (edge_sel_q),
        .frame_err  (frame_err)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Driver: one frame, start bit then bit 0 first then stop bit.
    task automatic send_frame(input logic [W-1:0] w, input bit stop1, input bit expect_it);
        if (expect_it) exp_q.push_back(w);
        @(negedge clk) sdata = 1'b1;
        for (int i = 0; i < W; i++) begin
            @(negedge clk) sdata = w[i];
        end
        @(negedge clk) sdata = stop1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) sdata = 1'b0;
        end
    endtask

    // Monitor: strobe fall -> compare word; rise -> check width and recovery.
    logic         prev_w = 1'b1;
    logic [W-1:0] prev_d = '0;
    int           low_len = 0;
    bit           after_rise = 1'b0;
    logic [W-1:0] exp_w;

    always @(negedge clk) begin
        if (after_rise && rst_n && stby_n) check(wclk_n === 1'b1, "R7", wclk_n, 1);
        after_rise = 1'b0;
        if (prev_w && !wclk_n) begin
            check(prev_d === word_out, "R4", prev_d, word_out);
            if (exp_q.size() == 0) begin
                check(1'b0, "R3 unexpected strobe", word_out, 0);
            end else begin
                exp_w = exp_q.pop_front();
                check(word_out === exp_w, "R3", word_out, exp_w);
            end
            low_len = 1;
        end else if (!wclk_n) begin
            low_len++;
        end
        if (!prev_w && wclk_n && low_len > 0) begin
            check(low_len == LOWC, "R5", low_len, LOWC);
            after_rise = 1'b1;
            low_len = 0;
        end
        prev_w = wclk_n;
        prev_d = word_out;
    end

    logic [W-1:0] held;

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(word_out === '0, "R1 word", word_out, 0);
        check(wclk_n === 1'b1, "R1 wclk", wclk_n, 1);
        check(frame_err === 1'b0, "R1 ferr", frame_err, 0);
        @(negedge clk) rst_n = 1'b1;
        idle(3);

        // R9: edge select is status only
        edge_sel = 1'b1;
        @(negedge clk);
        check(edge_sel_q === 1'b1, "R9 follow", edge_sel_q, 1);
        edge_sel = 1'b0;
        @(negedge clk);
        check(edge_sel_q === 1'b0, "R9 follow", edge_sel_q, 0);
        check(word_out === '0 && wclk_n === 1'b1, "R9 no effect", word_out, 0);

        // R3 R4 R5: spaced words with distinct patterns
        send_frame(20'hABCDE, 1'b0, 1'b1); idle(40);
        send_frame(20'h00001, 1'b0, 1'b1); idle(40);
        send_frame(20'h80000, 1'b0, 1'b1); idle(40);
        send_frame(20'hFFFFF, 1'b0, 1'b1); idle(40);

        // R10 R7: back-to-back frames, second and third arrive during a pulse
        send_frame(20'h12345, 1'b0, 1'b1);
        send_frame(20'h6789A, 1'b0, 1'b1);
        send_frame(20'h5A5A5, 1'b0, 1'b1);
        idle(100);
        check(exp_q.size() == 0, "R10 all delivered", exp_q.size(), 0);

        // R6: bad stop bit drops the word and sets the sticky flag
        held = word_out;
        send_frame(20'h0F0F0, 1'b1, 1'b0); idle(40);
        check(frame_err === 1'b1, "R6 flag", frame_err, 1);
        check(word_out === held, "R6 dropped", word_out, held);
        send_frame(20'h33333, 1'b0, 1'b1); idle(40);
        check(frame_err === 1'b1, "R6 sticky", frame_err, 1);

        // R2: standby holds outputs whatever arrives
        held = word_out;
        @(negedge clk) stby_n = 1'b0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk) sdata = (i % 3 != 1);
            check(wclk_n === 1'b1 && word_out === held, "R2 hold", word_out, held);
        end
        @(negedge clk) begin sdata = 1'b0; stby_n = 1'b1; end
        idle(3);

        // R8: standby mid-frame aborts the partial frame
        @(negedge clk) sdata = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk) sdata = i[0];
        end
        @(negedge clk) begin sdata = 1'b0; stby_n = 1'b0; end
        idle(2);
        @(negedge clk) stby_n = 1'b1;
        idle(3);
        send_frame(20'hC0FFE, 1'b0, 1'b1); idle(40);
        check(word_out === 20'hC0FFE, "R8 clean frame", word_out, 20'hC0FFE);

        // R1: reset mid-frame clears outputs and flag and discards the frame
        @(negedge clk) sdata = 1'b1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk) sdata = 1'b1;
        end
        @(negedge clk) begin sdata = 1'b0; rst_n = 1'b0; end
        @(negedge clk);
        check(word_out === '0, "R1 word", word_out, 0);
        check(wclk_n === 1'b1, "R1 wclk", wclk_n, 1);
        check(frame_err === 1'b0, "R1 ferr", frame_err, 0);
        @(negedge clk) rst_n = 1'b1;
        idle(3);
        send_frame(20'h00F00, 1'b0, 1'b1); idle(40);
        check(word_out === 20'h00F00, "R1 after abort", word_out, 20'h00F00);
        check(exp_q.size() == 0, "R3 queue empty", exp_q.size(), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule